// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDRAM device from power-up to normal operation and then keeps it refreshed. Software programs a control word whose operation field names one command: precharge of all banks, a single auto-refresh, or a load of the device mode register. The block places that command on the SDRAM command bus for one cycle. The operation value "normal" issues nothing on the bus. It only updates the refresh-enable bit.

Bring-up is done entirely by software writes, in this order:
1. A normal write.
2. One precharge-all.
3. Eight single-refresh writes.
4. A mode-register load.
5. A final normal write with refresh enabled.

Once refresh is enabled, a two-stage timer (a 16-bit prescaler feeding an 8-bit refresh counter) requests an auto-refresh at a fixed period. That request is served ahead of any software command that is waiting. Every command is followed by a minimum number of idle cycles. While a command is waiting or its idle gap is running, the block reports busy. A register write arriving then is parked in a one-entry slot and applied once the block is free.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset, and in every cycle without a command, the bus shows NOP with address and bank zero, and busy is low after reset. NOP is {cs_n,ras_n,cas_n,we_n}=0111.
- R2: A control write (select 0) with operation field bits [2:0]=1 issues exactly one precharge-all command (0010). Address bit 10 is high, and every other address bit and the bank are zero.
- R3: A control write with operation 2 issues exactly one auto-refresh (0001), so eight such writes give eight refreshes.
- R4: A control write with operation 3 issues one load-mode command (0000). The address carries control bits [4+ADDR_W-1:4] and the bank carries the BA_W bits directly above them.
- R5: A control write with operation 0, or with an unassigned value 4 to 7, issues no command. Bit 3 of every control write sets or clears refresh enable.
- R6: Any two commands on the bus are separated by at least GAP_CYC NOP cycles.
- R7: Busy rises in the cycle after an accepted command write. It stays high until the command has issued and its idle gap has run. A write made while busy is held and applied afterwards, not lost.
- R8: With refresh enabled, auto-refresh commands follow one another every (P+1)*(T+1) cycles. P is written with select 1 (bits [15:0]) and T with select 2 (bits [7:0]).
- R9: With refresh disabled, no automatic refresh is issued.
- R10: When a refresh request and a software command become due in the same cycle, the refresh is issued first and the software command follows after the idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 prescaler, 2 refresh count |
| reg_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | A command is waiting, a write is parked, or an idle gap is running |
| sd_cs_no | output | 1 | SDRAM chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank address |
| sd_addr_o | output | ADDR_W | Address |

## Verification
The assertions check on every cycle:
- the NOP bus encoding and zero address and bank between commands;
- A10 on every precharge;
- the minimum idle gap between commands;
- that busy follows an accepted command write, and stays high after a write that arrived while busy.

The following can only be shown by the bench's scenarios:
- the exact command sequence of bring-up, the mode-load address and bank contents, and that parked writes are applied later;
- the measured refresh period and the silence with refresh disabled;
- the ordering when a refresh and a software command fall due together.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam logic [2:0] OP_NORMAL = 3'd0;
  localparam logic [2:0] OP_PREA   = 3'd1;
  localparam logic [2:0] OP_CBR    = 3'd2;
  localparam logic [2:0] OP_MRW    = 3'd3;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_PRESC = 2'd1;
  localparam logic [1:0] SEL_TIMER = 2'd2;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PREA = 4'b0010,
    CMD_NOP  = 4'b0111
  } seq_cmd_e;
endpackage

// File: rtl/sdram_seq_regs.sv
module sdram_seq_regs
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int PRESC_W = 16,
  parameter int TIMER_W = 8,
  parameter int DATA_W  = 4 + ADDR_W + BA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               idle_i,
  input  logic               cmd_ack_i,
  output logic               busy_o,
  output logic               cmd_req_o,
  output logic [2:0]         cmd_op_o,
  output logic [ADDR_W-1:0]  mode_bits_o,
  output logic [BA_W-1:0]    ba_bits_o,
  output logic               ref_en_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [TIMER_W-1:0] timer_o
);
  localparam int MB_LSB = 4;
  localparam int BA_LSB = MB_LSB + ADDR_W;

  logic              held_v_q;
  logic [1:0]        held_sel_q;
  logic [DATA_W-1:0] held_data_q;
  logic              cmd_req_q;
  logic              busy, drain, app_v, app_cmd;
  logic [1:0]        app_sel;
  logic [DATA_W-1:0] app_data;
  logic [2:0]        app_op;

  always_comb begin
    busy     = cmd_req_q | ~idle_i | held_v_q;
    drain    = held_v_q & ~cmd_req_q & idle_i;
    app_v    = (we_i & ~busy) | drain;
    app_sel  = drain ? held_sel_q  : sel_i;
    app_data = drain ? held_data_q : wdata_i;
    app_op   = app_data[2:0];
    app_cmd  = (app_op == OP_PREA) || (app_op == OP_CBR) || (app_op == OP_MRW);
  end

  // one-entry parking slot for writes that arrive while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_q    <= 1'b0;
      held_sel_q  <= '0;
      held_data_q <= '0;
    end else if (we_i && busy) begin
      held_v_q    <= 1'b1;
      held_sel_q  <= sel_i;
      held_data_q <= wdata_i;
    end else if (drain) begin
      held_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_req_q   <= 1'b0;
      cmd_op_o    <= OP_NORMAL;
      mode_bits_o <= '0;
      ba_bits_o   <= '0;
      ref_en_o    <= 1'b0;
      presc_o     <= '0;
      timer_o     <= '0;
    end else begin
      if (cmd_ack_i) cmd_req_q <= 1'b0;
      if (app_v) begin
        case (app_sel)
          SEL_CTRL: begin
            ref_en_o    <= app_data[3];
            mode_bits_o <= app_data[MB_LSB +: ADDR_W];
            ba_bits_o   <= app_data[BA_LSB +: BA_W];
            if (app_cmd) begin
              cmd_req_q <= 1'b1;
              cmd_op_o  <= app_op;
            end
          end
          SEL_PRESC: presc_o <= app_data[PRESC_W-1:0];
          SEL_TIMER: timer_o <= app_data[TIMER_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign busy_o    = busy;
  assign cmd_req_o = cmd_req_q;
endmodule

// File: rtl/sdram_seq_reftimer.sv
module sdram_seq_reftimer #(
  parameter int PRESC_W = 16,
  parameter int TIMER_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_en_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [TIMER_W-1:0] timer_i,
  input  logic               ref_ack_i,
  output logic               ref_req_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [TIMER_W-1:0] tmr_q;
  logic               tick, expire;

  assign tick   = ref_en_i && (presc_q == '0);
  assign expire = tick && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      tmr_q   <= '0;
    end else if (!ref_en_i) begin
      presc_q <= presc_i;
      tmr_q   <= timer_i;
    end else begin
      presc_q <= (presc_q == '0) ? presc_i : presc_q - 1'b1;
      if (tick) tmr_q <= (tmr_q == '0) ? timer_i : tmr_q - 1'b1;
    end
  end

  // a new expiry wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_req_o <= 1'b0;
    else if (expire)    ref_req_o <= 1'b1;
    else if (ref_ack_i) ref_req_o <= 1'b0;
  end
endmodule

// File: rtl/sdram_seq_issue.sv
module sdram_seq_issue
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int GAP_CYC = 3,
  parameter int AP_BIT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_req_i,
  input  logic              cmd_req_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] mode_bits_i,
  input  logic [BA_W-1:0]   ba_bits_i,
  output logic              ref_ack_o,
  output logic              cmd_ack_o,
  output logic              idle_o,
  output seq_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  localparam int GW = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_L = GW'(GAP_CYC);

  logic [GW-1:0] gap_q;

  assign idle_o    = (gap_q == '0);
  assign ref_ack_o = idle_o & ref_req_i;
  assign cmd_ack_o = idle_o & ~ref_req_i & cmd_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      ba_o   <= '0;
      gap_q  <= '0;
    end else begin
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      ba_o   <= '0;
      if (ref_ack_o) begin
        cmd_o <= CMD_REF;
        gap_q <= GAP_L;
      end else if (cmd_ack_o) begin
        gap_q <= GAP_L;
        case (cmd_op_i)
          OP_PREA: begin
            cmd_o          <= CMD_PREA;
            addr_o[AP_BIT] <= 1'b1;
          end
          OP_MRW: begin
            cmd_o  <= CMD_MRS;
            addr_o <= mode_bits_i;
            ba_o   <= ba_bits_i;
          end
          default: cmd_o <= CMD_REF;
        endcase
      end else if (!idle_o) begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int PRESC_W = 16,
  parameter int TIMER_W = 8,
  parameter int GAP_CYC = 3,
  parameter int AP_BIT  = 10,
  parameter int DATA_W  = 4 + ADDR_W + BA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              busy_o,
  output logic              sd_cs_no,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ADDR_W-1:0] sd_addr_o
);
  logic               idle, cmd_ack, ref_ack, cmd_req, ref_req, ref_en;
  logic [2:0]         cmd_op;
  logic [ADDR_W-1:0]  mode_bits;
  logic [BA_W-1:0]    ba_bits;
  logic [PRESC_W-1:0] presc;
  logic [TIMER_W-1:0] timer;
  seq_cmd_e           cmd;

  sdram_seq_regs #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .PRESC_W(PRESC_W), .TIMER_W(TIMER_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .idle_i(idle), .cmd_ack_i(cmd_ack), .busy_o(busy_o), .cmd_req_o(cmd_req),
    .cmd_op_o(cmd_op), .mode_bits_o(mode_bits), .ba_bits_o(ba_bits), .ref_en_o(ref_en),
    .presc_o(presc), .timer_o(timer)
  );

  sdram_seq_reftimer #(.PRESC_W(PRESC_W), .TIMER_W(TIMER_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_en_i(ref_en), .presc_i(presc), .timer_i(timer),
    .ref_ack_i(ref_ack), .ref_req_o(ref_req)
  );

  sdram_seq_issue #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_CYC(GAP_CYC), .AP_BIT(AP_BIT)
  ) u_issue (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_req_i(ref_req), .cmd_req_i(cmd_req),
    .cmd_op_i(cmd_op), .mode_bits_i(mode_bits), .ba_bits_i(ba_bits),
    .ref_ack_o(ref_ack), .cmd_ack_o(cmd_ack), .idle_o(idle),
    .cmd_o(cmd), .addr_o(sd_addr_o), .ba_o(sd_ba_o)
  );

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int GAP_CYC = 3,
  parameter int AP_BIT  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [2:0]        op_i,
  input logic              busy_o,
  input logic              sd_cs_no,
  input logic              sd_ras_no,
  input logic              sd_cas_no,
  input logic              sd_we_no,
  input logic [BA_W-1:0]   sd_ba_o,
  input logic [ADDR_W-1:0] sd_addr_o
);
  localparam int IW = $clog2(GAP_CYC + 2);
  localparam logic [IW-1:0] GAP_L = IW'(GAP_CYC);

  logic [3:0]    cmd;
  logic [IW-1:0] idle_q;
  logic          cmd_wr;

  assign cmd    = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};
  assign cmd_wr = reg_we_i && !busy_o && (reg_sel_i == SEL_CTRL) &&
                  ((op_i == OP_PREA) || (op_i == OP_CBR) || (op_i == OP_MRW));

  // NOP cycles since the last command, saturating at the gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idle_q <= GAP_L;
    else if (cmd != CMD_NOP)  idle_q <= '0;
    else if (idle_q < GAP_L)  idle_q <= idle_q + 1'b1;
  end

  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_NOP) |-> (sd_addr_o == '0 && sd_ba_o == '0)); // R1

  AST_PREA_A10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PREA) |-> sd_addr_o[AP_BIT]); // R2

  AST_CMD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP) |-> (idle_q >= GAP_L)); // R6

  AST_BUSY_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> busy_o); // R7

  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && busy_o) |=> busy_o); // R7
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_CYC(GAP_CYC), .AP_BIT(AP_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .op_i(reg_wdata_i[2:0]), .busy_o(busy_o), .sd_cs_no(sd_cs_no), .sd_ras_no(sd_ras_no),
  .sd_cas_no(sd_cas_no), .sd_we_no(sd_we_no), .sd_ba_o(sd_ba_o), .sd_addr_o(sd_addr_o)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int DW     = 4 + ADDR_W + BA_W;
  localparam int GAP    = 3;
  localparam int PV     = 3;
  localparam int TV     = 4;
  localparam int PERIOD = (PV + 1) * (TV + 1);
  localparam logic [3:0] NOP = 4'b0111, PREA = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  typedef struct {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;
    string             req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic busy, cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  int checks = 0, errors = 0, cyc = 0, cmd_seen = 0, idle_run = 100;
  bit strict = 1'b1;
  exp_t q[$];
  int ref_times[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_CYC(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .busy_o(busy), .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n), .sd_we_no(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ctl(input logic [2:0] op, input logic en,
                                         input logic [ADDR_W-1:0] m, input logic [BA_W-1:0] b);
    return {b, m, en, op};
  endfunction

  task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                      input logic [BA_W-1:0] b, input string r);
    exp_t e;
    e.cmd = c; e.addr = a; e.ba = b; e.req = r;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    while (busy) @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0 || busy) @(negedge clk);
    repeat (GAP + 2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // monitor: compares bus commands against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (c != NOP) begin
        cmd_seen++;
        check(idle_run >= GAP, "R6 idle gap", idle_run, GAP);
        idle_run = 0;
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(c == e.cmd, e.req, int'(c), int'(e.cmd));
          check(addr == e.addr && ba == e.ba, e.req, int'({ba, addr}), int'({e.ba, e.addr}));
        end else if (strict) begin
          check(1'b0, "R5/R9 unexpected command", int'(c), int'(NOP));
        end else if (c == REF) begin
          ref_times.push_back(cyc);
        end
      end else begin
        idle_run++;
        check(addr == '0 && ba == '0, "R1 NOP bus quiet", int'({ba, addr}), 0);
      end
    end
  end

  initial begin
    int base;
    repeat (2) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == NOP && addr == '0 && ba == '0, "R1 reset bus",
          int'({cs_n, ras_n, cas_n, we_n}), int'(NOP));
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);

    // bring-up: normal, precharge-all, 8 refreshes, mode load
    base = cmd_seen;
    wr(2'd0, ctl(3'd0, 1'b0, '0, '0));
    repeat (6) @(negedge clk);
    check(cmd_seen == base, "R5 normal issues nothing", cmd_seen - base, 0);
    wr(2'd0, ctl(3'd5, 1'b0, 13'h1ff, 2'd3));
    repeat (6) @(negedge clk);
    check(cmd_seen == base, "R5 unassigned op issues nothing", cmd_seen - base, 0);

    push(PREA, 13'h400, '0, "R2 precharge-all");
    wr(2'd0, ctl(3'd1, 1'b0, 13'h0a5, 2'd2));
    for (int i = 0; i < 8; i++) begin
      push(REF, '0, '0, "R3 single refresh");
      wr(2'd0, ctl(3'd2, 1'b0, '0, '0));
    end
    push(MRS, 13'h032, 2'd1, "R4 mode load");
    wr(2'd0, ctl(3'd3, 1'b0, 13'h032, 2'd1));
    drain();
    check(cmd_seen - base == 10, "R3 command count in bring-up", cmd_seen - base, 10);

    // R7: busy after a command write, second write parked and applied
    push(PREA, 13'h400, '0, "R7 first of pair");
    push(REF, '0, '0, "R7 parked write applied");
    wr(2'd0, ctl(3'd1, 1'b0, '0, '0));
    check(busy == 1'b1, "R7 busy after command write", busy, 1);
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = ctl(3'd2, 1'b0, '0, '0);
    @(negedge clk);
    reg_we = 1'b0;
    check(busy == 1'b1, "R7 busy while write parked", busy, 1);
    drain();
    check(q.size() == 0, "R7 queue consumed", q.size(), 0);

    // R8: periodic refresh
    wr(2'd1, DW'(PV));
    wr(2'd2, DW'(TV));
    strict = 1'b0;
    wr(2'd0, ctl(3'd0, 1'b1, '0, '0));
    while (ref_times.size() < 5) @(negedge clk);
    for (int i = 1; i < 5; i++)
      check(ref_times[i] - ref_times[i-1] == PERIOD, "R8 refresh period",
            ref_times[i] - ref_times[i-1], PERIOD);

    // R10: refresh and software command due in the same cycle
    begin
      int n, last;
      n = ref_times.size();
      while (ref_times.size() == n) @(negedge clk);
      last = ref_times[n];
      while (cyc != last + PERIOD - 2) @(negedge clk);
      push(REF, '0, '0, "R10 refresh first");
      push(PREA, 13'h400, '0, "R10 command second");
      reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = ctl(3'd1, 1'b1, '0, '0);
      @(negedge clk);
      reg_we = 1'b0;
      drain();
      check(q.size() == 0, "R10 both issued", q.size(), 0);
    end

    // R9: refresh disabled stays silent
    wr(2'd0, ctl(3'd0, 1'b0, '0, '0));
    repeat (GAP + 4) @(negedge clk);
    strict = 1'b1;
    base = cmd_seen;
    repeat (3 * PERIOD) @(negedge clk);
    check(cmd_seen == base, "R9 no refresh when disabled", cmd_seen - base, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule